// File: doc/BRIEF.md
# UART interrupt status controller

This block gathers eight single-cycle event pulses from a serial port (receive errors, receive data and timeout, transmitter idle and transmit space) into sticky status bits. Each pending bit is masked by a software enable bit. The masked result drives a single level-sensitive interrupt line.

Software reaches the block through a 32-bit register window addressed by byte offset. Four word registers sit near the top of a 4 KB space:

- A read-only view of the pending events.
- A read/write enable mask.
- A write-one-to-clear register that acknowledges events.
- A write-one-to-set register that forces events for testing.

The six low event bits form the receive group and the two high bits form the transmit group. A driver can therefore acknowledge one group with a single mask write.

A handler reads the pending bits, services them and writes the same bits to the clear register. Software can mask an event that it polls, and enable it later without seeing an interrupt left over from an earlier occurrence.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the pending register (offset 0xFE0) and the enable register (offset 0xFE4) both read 0, and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[i]` sets pending bit i. The bit stays set until software clears it. Bit meanings:
  - bit 0: parity error
  - bit 1: break received
  - bit 2: framing error
  - bit 3: receive overrun
  - bit 4: byte received
  - bit 5: receiver timeout
  - bit 6: transmitter fully empty
  - bit 7: transmit space available
- R3: The enable register at 0xFE4 can be written and read back. Only bits 7:0 are stored, and bits 31:8 read as 0.
- R4: Writing offset 0xFE8 clears every pending bit whose write-data bit is 1 and leaves bits written 0 unchanged. Writing 0x3F clears only the receive group (bits 5:0), and writing 0xFFFFFFFF clears all bits.
- R5: Writing offset 0xFEC sets every pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: If an event pulse on bit i arrives in the same cycle as a clear of bit i, pending bit i is set after that cycle, so the event is not lost.
- R7: `irq_o` is high exactly one clock after (pending AND enable) is nonzero, and low one clock after it becomes zero. A pending bit whose enable is 0 never raises `irq_o`.
- R8: If an event is cleared while it is masked and its enable is set afterwards, `irq_o` stays low. A later event on that enabled bit does raise `irq_o`.
- R9: The pending register ignores writes. The clear and set offsets read as 0, and so does any unmapped offset (for example 0x000).
- R10: Read data appears on `rdata_o` in the cycle after the clock edge that accepts the read request, and it reflects the register state before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one bit per source, one cycle wide |
| req_i | input | 1 | Register access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset into the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each result has a fixed latency from its stimulus:

- An event pulse or register write accepted at an edge changes the pending and enable state at that same edge.
- A read accepted at an edge returns its data on `rdata_o` from that edge on.
- `irq_o` follows a change in pending state one edge later.

The bench drives inputs on falling edges. A read pushes its expected word into a queue, and a monitor pops that word and compares it at the falling edge after the accepting rising edge. The interrupt line is sampled twice after each event or clear: once at the falling edge straight after the change, where it must still show the old level, and again one cycle later, where it must show the new level.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   // Default geometry of the event set
   localparam int unsigned UIRQ_EVT_N  = 8;
   localparam int unsigned UIRQ_RX_W   = 6;

   // Event source positions (software-visible bit order)
   typedef enum int unsigned {
      EV_PARITY  = 0,
      EV_BREAK   = 1,
      EV_FRAMING = 2,
      EV_OVERRUN = 3,
      EV_RXBYTE  = 4,
      EV_RXTMO   = 5,
      EV_TXIDLE  = 6,
      EV_TXSPACE = 7
   } uirq_evt_e;

   // Register selected by the current access
   typedef enum logic [2:0] {
      REG_NONE,
      REG_PEND,
      REG_MASK,
      REG_ACK,
      REG_FORCE
   } uirq_reg_e;
endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N      = UIRQ_EVT_N,
   parameter logic [ADDR_W-1:0] OFS_PEND  = 12'hFE0,
   parameter logic [ADDR_W-1:0] OFS_MASK  = 12'hFE4,
   parameter logic [ADDR_W-1:0] OFS_ACK   = 12'hFE8,
   parameter logic [ADDR_W-1:0] OFS_FORCE = 12'hFEC
)(
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output uirq_reg_e         sel_o,
   output logic              rd_o,
   output logic              mask_wr_o,
   output logic [N-1:0]      mask_d_o,
   output logic [N-1:0]      ack_o,
   output logic [N-1:0]      force_o
);
   localparam int unsigned WA_W = ADDR_W - 2;

   logic [WA_W-1:0] waddr;
   logic [N-1:0]    wbits;
   logic            wr;

   assign waddr = addr_i[ADDR_W-1:2];
   assign wbits = wdata_i[N-1:0];
   assign wr    = req_i & we_i;
   assign rd_o  = req_i & ~we_i;

   generate
      if (DATA_W > N) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^{wdata_i[DATA_W-1:N], addr_i[1:0]};
      end else begin : g_nospare
         logic unused_lo;
         assign unused_lo = ^addr_i[1:0];
      end
   endgenerate

   always_comb begin
      sel_o = REG_NONE;
      if (waddr == OFS_PEND[ADDR_W-1:2])       sel_o = REG_PEND;
      else if (waddr == OFS_MASK[ADDR_W-1:2])  sel_o = REG_MASK;
      else if (waddr == OFS_ACK[ADDR_W-1:2])   sel_o = REG_ACK;
      else if (waddr == OFS_FORCE[ADDR_W-1:2]) sel_o = REG_FORCE;
   end

   assign mask_wr_o = wr && (sel_o == REG_MASK);
   assign mask_d_o  = wbits;
   assign ack_o     = (wr && (sel_o == REG_ACK))   ? wbits : '0;
   assign force_o   = (wr && (sel_o == REG_FORCE)) ? wbits : '0;
endmodule

// File: rtl/uirq_cell.sv
module uirq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic ack_i,
   input  logic force_i,
   output logic q_o
);
   // A new event or a forced set takes priority over an acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= force_i | evt_i | (q_o & ~ack_i);
   end
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
   parameter int unsigned N = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= d_i;
   end
endmodule

// File: rtl/uirq_line.sv
module uirq_line #(
   parameter int unsigned N          = 8,
   parameter bit          REGISTERED = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] mask_i,
   output logic         irq_o
);
   logic any_live;
   assign any_live = |(pend_i & mask_i);

   generate
      if (REGISTERED) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= any_live;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq_o = any_live;
      end
   endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_EVT   = UIRQ_EVT_N,
   parameter bit          IRQ_REG = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_PEND  = 12'hFE0,
   parameter logic [ADDR_W-1:0] OFS_MASK  = 12'hFE4,
   parameter logic [ADDR_W-1:0] OFS_ACK   = 12'hFE8,
   parameter logic [ADDR_W-1:0] OFS_FORCE = 12'hFEC
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   initial begin
      assert (N_EVT >= 1 && N_EVT <= DATA_W)
         else $fatal(1, "N_EVT must be between 1 and DATA_W");
      assert (ADDR_W >= 3)
         else $fatal(1, "ADDR_W too small for word registers");
      assert (OFS_PEND[1:0] == 2'b00 && OFS_MASK[1:0] == 2'b00 &&
              OFS_ACK[1:0] == 2'b00 && OFS_FORCE[1:0] == 2'b00)
         else $fatal(1, "register offsets must be word aligned");
   end

   uirq_reg_e      sel;
   logic           rd;
   logic           mask_wr;
   logic [N_EVT-1:0] mask_d;
   logic [N_EVT-1:0] ack;
   logic [N_EVT-1:0] frc;
   logic [N_EVT-1:0] status_q;
   logic [N_EVT-1:0] enable_q;
   logic [DATA_W-1:0] rmux;
   logic [DATA_W-1:0] rdata_q;

   uirq_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N_EVT),
      .OFS_PEND(OFS_PEND), .OFS_MASK(OFS_MASK),
      .OFS_ACK(OFS_ACK), .OFS_FORCE(OFS_FORCE)
   ) u_dec (
      .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .sel_o(sel), .rd_o(rd), .mask_wr_o(mask_wr), .mask_d_o(mask_d),
      .ack_o(ack), .force_o(frc)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_EVT; gi++) begin : g_bit
         uirq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .evt_i(evt_i[gi]),
            .ack_i(ack[gi]), .force_i(frc[gi]), .q_o(status_q[gi])
         );
      end
   endgenerate

   uirq_mask #(.N(N_EVT)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_i(mask_wr), .d_i(mask_d), .q_o(enable_q)
   );

   uirq_line #(.N(N_EVT), .REGISTERED(IRQ_REG)) u_line (
      .clk(clk), .rst_n(rst_n), .pend_i(status_q), .mask_i(enable_q),
      .irq_o(irq_o)
   );

   always_comb begin
      rmux = '0;
      case (sel)
         REG_PEND: rmux = DATA_W'(status_q);
         REG_MASK: rmux = DATA_W'(enable_q);
         default:  rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rmux;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
   parameter int unsigned N      = 8,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] OFS_PEND  = 12'hFE0,
   parameter logic [ADDR_W-1:0] OFS_ACK   = 12'hFE8,
   parameter logic [ADDR_W-1:0] OFS_FORCE = 12'hFEC
)(
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      evt_i,
   input logic              req_i,
   input logic              we_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [N-1:0]      status_i,
   input logic [N-1:0]      enable_i,
   input logic              irq_i
);
   logic         wr;
   logic         ack_hit;
   logic         frc_hit;
   logic         pend_hit;
   logic [N-1:0] ack_bits;
   logic [N-1:0] frc_bits;
   logic         unused_chk;

   assign wr       = req_i & we_i;
   assign ack_hit  = wr && (addr_i[ADDR_W-1:2] == OFS_ACK[ADDR_W-1:2]);
   assign frc_hit  = wr && (addr_i[ADDR_W-1:2] == OFS_FORCE[ADDR_W-1:2]);
   assign pend_hit = wr && (addr_i[ADDR_W-1:2] == OFS_PEND[ADDR_W-1:2]);
   assign ack_bits = ack_hit ? wdata_i[N-1:0] : '0;
   assign frc_bits = frc_hit ? wdata_i[N-1:0] : '0;
   assign unused_chk = ^{addr_i[1:0], wdata_i};

   // R2: an event leaves its pending bit set
   p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((status_i & $past(evt_i)) == $past(evt_i)));

   // R4: acknowledged bits drop when no event or force hits them
   p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && ((evt_i | frc_bits) == '0)) |=> ((status_i & $past(ack_bits)) == '0));

   // R4: bits not acknowledged keep their value
   p_ack_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(status_i) & ~$past(ack_bits))) & ~status_i) == '0));

   // R5: forced bits are set
   p_force_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frc_hit |=> ((status_i & $past(frc_bits)) == $past(frc_bits)));

   // R7: the line is high only if a live enabled event existed one cycle earlier
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |-> ($past(status_i & enable_i) != '0));

   // R7: a live enabled event raises the line on the next edge
   p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_i & enable_i) != '0) |=> irq_i);

   // R9: a write to the pending register changes nothing by itself
   p_pend_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_hit && (evt_i == '0)) |=> (status_i == $past(status_i)));
endmodule

bind uart_irq_ctrl uirq_chk #(
   .N(N_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .OFS_PEND(OFS_PEND), .OFS_ACK(OFS_ACK), .OFS_FORCE(OFS_FORCE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .req_i(req_i), .we_i(we_i),
   .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status_q),
   .enable_i(enable_q), .irq_i(irq_o)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_PEND  = 12'hFE0;
   localparam logic [11:0] A_MASK  = 12'hFE4;
   localparam logic [11:0] A_ACK   = 12'hFE8;
   localparam logic [11:0] A_FORCE = 12'hFEC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt = '0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: a read accepted at a rising edge is compared at the next falling edge (R10)
   initial begin
      forever begin
         bit was_rd;
         @(posedge clk);
         was_rd = req && !we && rst_n;
         @(negedge clk);
         if (was_rd) begin
            if (exp_q.size() == 0) begin
               check("R10 unexpected read", 32'h1, 32'h0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, rdata, e);
            end
         end
      end
   end

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      evt = m;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      check("watchdog expired", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      idle(3);
      check("R1 irq in reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      idle(1);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      bus_rd(A_PEND, 32'h0, "R1 pending after reset");
      bus_rd(A_MASK, 32'h0, "R1 enable after reset");

      // R3: enable readback, upper bits not stored
      bus_wr(A_MASK, 32'hFFFF_FFFF);
      bus_rd(A_MASK, 32'h0000_00FF, "R3 enable all ones");
      bus_wr(A_MASK, 32'h0000_005A);
      bus_rd(A_MASK, 32'h0000_005A, "R3 enable pattern");
      bus_wr(A_MASK, 32'h0);

      // R2: sticky events, receive and transmit bits
      pulse(8'h01);
      bus_rd(A_PEND, 32'h01, "R2 parity event");
      pulse(8'h80);
      idle(2);
      bus_rd(A_PEND, 32'h81, "R2 tx space event sticky");
      check("R7 masked pending keeps irq low", {31'b0, irq}, 32'h0);

      // R4: write-one clear
      bus_wr(A_ACK, 32'h01);
      bus_rd(A_PEND, 32'h80, "R4 clear one bit");
      bus_wr(A_ACK, 32'h00);
      bus_rd(A_PEND, 32'h80, "R4 zero write keeps bits");

      // R5: write-one set
      bus_wr(A_FORCE, 32'h3F);
      bus_rd(A_PEND, 32'hBF, "R5 force receive group");
      bus_wr(A_ACK, 32'h3F);
      bus_rd(A_PEND, 32'h80, "R4 clear receive group only");
      bus_wr(A_ACK, 32'hFFFF_FFFF);
      bus_rd(A_PEND, 32'h00, "R4 clear all");

      // R6: event and clear of the same bit in one cycle
      bus_wr(A_FORCE, 32'h08);
      evt = 8'h08;
      req = 1'b1; we = 1'b1; addr = A_ACK; wdata = 32'h08;
      @(negedge clk);
      evt = '0; req = 1'b0; we = 1'b0;
      bus_rd(A_PEND, 32'h08, "R6 event survives clear");
      evt = 8'h02;
      req = 1'b1; we = 1'b1; addr = A_ACK; wdata = 32'h08;
      @(negedge clk);
      evt = '0; req = 1'b0; we = 1'b0;
      bus_rd(A_PEND, 32'h02, "R6 other bit cleared, new event kept");
      bus_wr(A_ACK, 32'hFF);

      // R7: registered interrupt timing
      bus_wr(A_MASK, 32'h10);
      pulse(8'h10);
      check("R7 irq not yet high", {31'b0, irq}, 32'h0);
      idle(1);
      check("R7 irq high one cycle later", {31'b0, irq}, 32'h1);
      pulse(8'h01);
      idle(1);
      check("R7 disabled event no effect", {31'b0, irq}, 32'h1);
      bus_wr(A_ACK, 32'h10);
      check("R7 irq still high after clear edge", {31'b0, irq}, 32'h1);
      idle(1);
      check("R7 irq low one cycle after clear", {31'b0, irq}, 32'h0);
      bus_wr(A_ACK, 32'hFF);
      bus_wr(A_MASK, 32'h0);

      // R8: no stale interrupt after clear then enable
      pulse(8'h20);
      bus_wr(A_ACK, 32'h20);
      bus_wr(A_MASK, 32'h20);
      idle(1);
      check("R8 no stale irq", {31'b0, irq}, 32'h0);
      idle(2);
      check("R8 no stale irq later", {31'b0, irq}, 32'h0);
      pulse(8'h20);
      idle(1);
      check("R8 fresh event raises irq", {31'b0, irq}, 32'h1);
      bus_wr(A_ACK, 32'hFF);
      bus_wr(A_MASK, 32'h0);
      idle(1);
      check("R8 irq low after cleanup", {31'b0, irq}, 32'h0);

      // R9: read-only pending, write-only clear/set, unmapped
      bus_wr(A_PEND, 32'hFF);
      bus_rd(A_PEND, 32'h0, "R9 pending ignores writes");
      bus_wr(A_FORCE, 32'h44);
      bus_rd(A_ACK, 32'h0, "R9 clear reads zero");
      bus_rd(A_FORCE, 32'h0, "R9 set reads zero");
      bus_rd(12'h000, 32'h0, "R9 unmapped reads zero");
      bus_rd(A_PEND, 32'h44, "R5 force pattern");

      idle(3);
      if (exp_q.size() != 0) check("R10 reads left unanswered", exp_q.size(), 0);
      finish_run();
   end
endmodule